// File: doc/BRIEF.md
# Status Change Alert Latch

This block sits between the fault-sensing logic of a power unit and its management bus engine. It watches a vector of condition levels (input voltage out of range, output voltage out of range, output over-current, temperature warning or fault, fan failure, internal fault) together with one-cycle error strobes from the bus engine (bus communication error, checksum error, unsupported command or invalid data). Any movement of a condition, whether it appears or goes away, and any error strobe is recorded in a sticky status bit, and an active-low alert line toward the host is pulled low for as long as any status bit is set.

The host releases the alert in one of four ways: a clear-faults strobe, a strobe marking a read of the status word, or the main output being switched off and then on again, either through the enable pin or through the bus on/off command. A release reloads every condition bit from the live condition levels, so a fault that is still present keeps its bit and keeps the alert low. A change seen in the same cycle as a release always wins over the release.

Top module: `smb_alert_latch`

## Requirements
- R1: After reset every status bit reads 0 and the alert output reads 1 (released). Throughout operation the alert output is 0 exactly when at least one status bit is 1.
- R2: A condition input whose level differs from its level in the previous cycle sets its status bit on the next clock edge. Condition k maps to status bit k. Both rising and falling levels count. The baseline after reset is all zero.
- R3: A status bit stays set in every cycle that has no release event.
- R4: A release event clears each error status bit and each condition status bit whose condition is low and unchanged. The alert returns to 1 when nothing is left set.
- R5: The release events are a one-cycle clear-faults strobe and a one-cycle status-word-read strobe. Each one acts on its own.
- R6: A release in a cycle where a condition input is high leaves that condition's status bit at 1 and the alert at 0.
- R7: Error strobe bit 0 (bus communication error) sets status bit NUM_COND. Bit 1 (checksum error) sets status bit NUM_COND+1. Bit 2 (unsupported command or invalid data) sets status bit NUM_COND+2. Each takes effect on the next clock edge.
- R8: A low-to-high transition on the enable pin level, or on the bus on/off command level, is a release event. A high-to-low transition on either leaves the status bits unchanged.
- R9: When a condition change or an error strobe occurs in the same cycle as a release event, the new bit is set after that edge and the alert stays at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cond_i | input | NUM_COND | Condition levels from fault sensing |
| bus_err_i | input | 3 | Error strobes from the bus engine (comm, checksum, command) |
| clear_faults_i | input | 1 | Clear-faults command strobe |
| status_read_i | input | 1 | Status word read strobe |
| en_pin_i | input | 1 | Output enable pin level |
| op_on_i | input | 1 | Bus on/off command level (1 = on) |
| alert_n_o | output | 1 | Active-low alert toward the host |
| status_o | output | NUM_COND+3 | Sticky status bits |

## Verification
Single conditions are driven at the lowest and highest positions, and the fault is held across a release before it is dropped. This separates change detection on falling levels from reloading on release. Each release source is driven alone on a clean status, and every output recycle is first held in the off state. This shows that only the off-to-on transition releases the alert. Releases that coincide with a new change or an error strobe show that the new event takes priority. A case with two conditions moving together shows that the bits are recorded independently.

// File: rtl/alert_pkg.sv
package alert_pkg;
    // Number of bus engine error strobe sources and their bit positions.
    localparam int NUM_ERR  = 3;
    localparam int ERR_COMM = 0;
    localparam int ERR_PEC  = 1;
    localparam int ERR_CMD  = 2;
    // Number of output recycle sources (enable pin, on/off command).
    localparam int NUM_RECYCLE = 2;
endpackage

// File: rtl/sal_change_det.sv
// Change detector: keeps a registered copy of the condition vector and
// flags every bit whose level differs from the previous cycle.
// Assumes conditions are synchronous to clk; baseline after reset is zero.
module sal_change_det #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cond_i,
    output logic [W-1:0] chg_o
);
    logic [W-1:0] cond_q;

    // Hold last cycle's condition levels.
    always_ff @(posedge clk) begin
        if (!rst_n) cond_q <= '0;
        else        cond_q <= cond_i;
    end

    // Any differing bit is a change.
    always_comb chg_o = cond_i ^ cond_q;
endmodule

// File: rtl/sal_clear_src.sv
// Release event source: merges the clear-faults and status-read strobes
// with off-to-on transitions of each output recycle level.
// Assumes strobes are one cycle wide; recycle levels are synchronous.
module sal_clear_src #(
    parameter int NR = alert_pkg::NUM_RECYCLE
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_faults_i,
    input  logic          status_read_i,
    input  logic [NR-1:0] recycle_lvl_i,
    output logic          clr_o
);
    logic [NR-1:0] lvl_q;
    logic [NR-1:0] rise;

    // Per-source previous level and rising-edge flag.
    for (genvar g = 0; g < NR; g++) begin : g_rcy
        always_ff @(posedge clk) begin
            if (!rst_n) lvl_q[g] <= 1'b0;
            else        lvl_q[g] <= recycle_lvl_i[g];
        end
        assign rise[g] = recycle_lvl_i[g] & ~lvl_q[g];
    end

    // Any source releases the alert.
    always_comb clr_o = clear_faults_i | status_read_i | (|rise);
endmodule

// File: rtl/sal_status_reg.sv
// Sticky status register: condition bits set on change and reloaded from
// live levels on release; error bits set on strobe and cleared on release.
// New events take priority over a release in the same cycle.
module sal_status_reg #(
    parameter int NC = 8,
    parameter int NE = alert_pkg::NUM_ERR,
    localparam int SW = NC + NE
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NC-1:0] cond_i,
    input  logic [NC-1:0] chg_i,
    input  logic [NE-1:0] err_i,
    input  logic          clr_i,
    output logic [SW-1:0] st_d_o,
    output logic [SW-1:0] st_o
);
    logic [SW-1:0] st_q;

    // Next state: set sources OR'd over held or reloaded value.
    always_comb begin
        st_d_o[NC-1:0]  = chg_i | (clr_i ? cond_i : st_q[NC-1:0]);
        st_d_o[SW-1:NC] = err_i | (clr_i ? '0 : st_q[SW-1:NC]);
    end

    // Status register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d_o;
    end

    assign st_o = st_q;

    AST_CHANGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (|chg_i) |=> ((st_q[NC-1:0] & $past(chg_i)) == $past(chg_i))); // R2
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((st_q & $past(st_q)) == $past(st_q))); // R3
    AST_PERSIST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> ((st_q[NC-1:0] & $past(cond_i)) == $past(cond_i))); // R6
    AST_ERR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (|err_i) |=> ((st_q[SW-1:NC] & $past(err_i)) == $past(err_i))); // R7
endmodule

// File: rtl/sal_alert_drv.sv
// Alert driver: registers an active-low alert that is low whenever the
// next status value has any bit set, so it tracks the status register.
module sal_alert_drv #(
    parameter int SW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] st_d_i,
    input  logic [SW-1:0] st_i,
    output logic          alert_n_o
);
    logic alert_n_q;

    // Alert register, released at reset.
    always_ff @(posedge clk) begin
        if (!rst_n) alert_n_q <= 1'b1;
        else        alert_n_q <= ~(|st_d_i);
    end

    assign alert_n_o = alert_n_q;

    AST_ALERT_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        alert_n_q == !(|st_i)); // R1
endmodule

// File: rtl/smb_alert_latch.sv
// Top: status change alert latch. Wires change detection, release event
// merging, the sticky status register and the alert driver.
// Assumes all inputs are synchronous to clk.
module smb_alert_latch #(
    parameter int NUM_COND = 8,
    localparam int NE = alert_pkg::NUM_ERR,
    localparam int SW = NUM_COND + NE
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_COND-1:0] cond_i,
    input  logic [NE-1:0]       bus_err_i,
    input  logic                clear_faults_i,
    input  logic                status_read_i,
    input  logic                en_pin_i,
    input  logic                op_on_i,
    output logic                alert_n_o,
    output logic [SW-1:0]       status_o
);
    logic [NUM_COND-1:0] chg;
    logic                clr;
    logic [SW-1:0]       st_d;

    sal_change_det #(.W(NUM_COND)) u_chg (
        .clk(clk), .rst_n(rst_n), .cond_i(cond_i), .chg_o(chg)
    );

    sal_clear_src #(.NR(alert_pkg::NUM_RECYCLE)) u_clr (
        .clk(clk), .rst_n(rst_n),
        .clear_faults_i(clear_faults_i), .status_read_i(status_read_i),
        .recycle_lvl_i({op_on_i, en_pin_i}), .clr_o(clr)
    );

    sal_status_reg #(.NC(NUM_COND), .NE(NE)) u_st (
        .clk(clk), .rst_n(rst_n), .cond_i(cond_i), .chg_i(chg),
        .err_i(bus_err_i), .clr_i(clr), .st_d_o(st_d), .st_o(status_o)
    );

    sal_alert_drv #(.SW(SW)) u_alr (
        .clk(clk), .rst_n(rst_n), .st_d_i(st_d), .st_i(status_o),
        .alert_n_o(alert_n_o)
    );

    AST_QUIET_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && chg == '0 && bus_err_i == '0 && cond_i == '0) |=> alert_n_o); // R4
    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && ((|chg) || (|bus_err_i))) |=> !alert_n_o); // R9
endmodule

// File: tb/sim_smb_alert_latch.sv
module sim_smb_alert_latch;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  cond;
    logic [2:0]  err;
    logic        clrf, rdst, pin, op;
    logic        alert_n;
    logic [10:0] status;

    int checks = 0;
    int fails  = 0;
    logic [10:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    smb_alert_latch #(.NUM_COND(8)) u0 (
        .clk(clk), .rst_n(rst_n), .cond_i(cond), .bus_err_i(err),
        .clear_faults_i(clrf), .status_read_i(rdst), .en_pin_i(pin),
        .op_on_i(op), .alert_n_o(alert_n), .status_o(status)
    );

    task automatic compare(input logic [10:0] exp_st, input string tag);
        checks++;
        if (status !== exp_st) begin
            fails++;
            $display("FAIL %s status actual=%03h expected=%03h", tag, status, exp_st);
        end
        checks++;
        if (alert_n !== (exp_st == 11'd0)) begin
            fails++;
            $display("FAIL %s alert_n actual=%b expected=%b", tag, alert_n, (exp_st == 11'd0));
        end
    endtask

    // Driver: apply one cycle of stimulus, queue the expected result.
    task automatic step(input logic [7:0] c, input logic [2:0] e,
                        input logic cf, input logic rs, input logic p,
                        input logic o, input logic [10:0] exp_st,
                        input string tag);
        @(negedge clk);
        cond = c; err = e; clrf = cf; rdst = rs; pin = p; op = o;
        @(posedge clk);
        exp_q.push_back(exp_st);
        tag_q.push_back(tag);
    endtask

    // Monitor: compare queued expectations away from the active edge.
    always @(negedge clk) begin
        if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
    end

    initial begin
        repeat (5000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cond = '0; err = '0; clrf = 0; rdst = 0; pin = 1; op = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare(11'h000, "R1 in reset");
        rst_n = 1'b1;
        step(8'h00, 3'b000, 0, 0, 1, 1, 11'h000, "R1 after reset");
        step(8'h01, 3'b000, 0, 0, 1, 1, 11'h001, "R2 bit0 rises");
        step(8'h01, 3'b000, 0, 0, 1, 1, 11'h001, "R3 held");
        step(8'h01, 3'b000, 1, 0, 1, 1, 11'h001, "R6 clear with fault present");
        step(8'h00, 3'b000, 0, 0, 1, 1, 11'h001, "R2 falling change");
        step(8'h00, 3'b000, 0, 1, 1, 1, 11'h000, "R5 status read releases");
        step(8'h00, 3'b000, 0, 0, 1, 1, 11'h000, "R4 stays released");
        step(8'h80, 3'b000, 0, 0, 1, 1, 11'h080, "R2 bit7 rises");
        step(8'h80, 3'b000, 0, 1, 1, 1, 11'h080, "R6 read with fault present");
        step(8'h00, 3'b000, 0, 0, 1, 1, 11'h080, "R3 falling keeps bit");
        step(8'h00, 3'b000, 1, 0, 1, 1, 11'h000, "R5 clear faults releases");
        step(8'h00, 3'b100, 0, 0, 1, 1, 11'h400, "R7 invalid command");
        step(8'h00, 3'b000, 0, 0, 1, 1, 11'h400, "R3 error sticky");
        step(8'h00, 3'b000, 0, 0, 0, 1, 11'h400, "R8 pin off no release");
        step(8'h00, 3'b000, 0, 0, 0, 1, 11'h400, "R8 pin held off");
        step(8'h00, 3'b000, 0, 0, 1, 1, 11'h000, "R8 pin on releases");
        step(8'h00, 3'b010, 0, 0, 1, 1, 11'h200, "R7 checksum error");
        step(8'h00, 3'b000, 0, 0, 1, 0, 11'h200, "R8 command off no release");
        step(8'h00, 3'b000, 0, 0, 1, 1, 11'h000, "R8 command on releases");
        step(8'h04, 3'b000, 0, 1, 1, 1, 11'h004, "R9 change beats read");
        step(8'h04, 3'b001, 0, 1, 1, 1, 11'h104, "R9 comm error beats read");
        step(8'h00, 3'b000, 1, 0, 1, 1, 11'h004, "R9 falling change beats clear");
        step(8'h00, 3'b000, 0, 1, 1, 1, 11'h000, "R4 read releases all");
        step(8'h30, 3'b000, 0, 0, 1, 1, 11'h030, "R2 two bits together");
        step(8'h30, 3'b000, 0, 0, 1, 1, 11'h030, "R3 two bits held");
        @(negedge clk);
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule